// File: doc/BRIEF.md
# Four-Channel PWM Comparator Unit

The unit derives four pulse-width modulated outputs and four interrupt lines from a single free-running counter. A 4-bit shift selects which slice of the counter the channels see (the scaled count), and each channel compares that slice against its own compare value. The counter runs either continuously or for exactly one counting cycle, and may be sent back to zero when channel 0 matches, which sets the PWM period.

Each channel can use a centre-aligned comparison that folds the scaled count around its midpoint, can be ganged with its neighbour so that its output marks the window between its own match and the neighbour's match, and can be deglitched so that its output stays high for the rest of the counting cycle once it has matched. Every match while running sets a pending bit that drives the channel's interrupt line; with the sticky option, software writes cannot clear a pending bit.

Software reaches the configuration word, the counter, the scaled count and the four compare values through a simple single-cycle register port with combinational read data.

Top module: `pwm4_unit`

## Requirements
- R1: After reset the configuration word and pending bits are zero, the counter is zero, every compare value is all ones, and all PWM outputs and interrupt lines are low.
- R2: Register offsets: configuration word 0x00, counter 0x08 (read/write), scaled count 0x10 (read only), compare value of channel n at 0x20 + 4*n; any other offset reads zero. Configuration bits: scale [3:0], sticky [8], zero-on-match [9], deglitch [10], run-always [12], one-shot [13], centre per channel [19:16], gang per channel [27:24], pending per channel [31:28].
- R3: The scaled count is the counter shifted right by the scale field, truncated to the low CMP_W bits.
- R4: Channel n matches when its comparison value (the scaled count unless centred) is greater than or equal to compare n; without gang or deglitch its output equals its match.
- R5: In centre mode the comparison value is the scaled count when its top bit is 0 and its bitwise inverse when its top bit is 1.
- R6: Gang bit n pairs channel n with channel (n+1) mod 4: a ganged output is high only while its own match is true and the partner's match is false.
- R7: The counter advances by one per clock while run-always or one-shot is set, wraps from all ones to zero, holds when neither is set, and a software write to it takes priority over counting.
- R8: With zero-on-match set and the counter running, a channel 0 match returns the counter to zero on the next clock.
- R9: Hardware clears the one-shot bit at the end of a counting cycle, whether that end is a wrap or a zero-on-match return.
- R10: A channel match while running sets its pending bit, and each interrupt line follows its pending bit; a configuration write replaces the pending bits, but a hardware set in the same cycle wins over a software clear.
- R11: While sticky is set, a configuration write cannot clear a set pending bit; with sticky clear it can.
- R12: With deglitch set, a channel output that has matched while running stays high until the counting cycle ends or the counter is written.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset for both write and read |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data at reg_addr |
| pwm_out | output | 4 | PWM outputs, one per channel |
| irq | output | 4 | Interrupt lines, one per channel pending bit |

## Verification
The pending bits have two writers that can act in one cycle: the hardware set from a running match and the software replacement through a configuration write. The bench sets compare 0 to zero so channel 0 matches on every running cycle, then writes the configuration word with the pending field cleared while the counter still runs; channel 0's interrupt must still be high right after that clock, whereas a second write made once the counter has stopped must clear it.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

   localparam int NUM_CH  = 4;
   localparam int REG_W   = 32;
   localparam int SCALE_W = 4;

   // register offsets
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_COUNT  = 'h08;
   localparam int OFS_SCALED = 'h10;
   localparam int OFS_CMP    = 'h20;
   localparam int CMP_STRIDE = 4;

   // configuration word bit positions
   localparam int B_SCALE_LO = 0;
   localparam int B_STICKY   = 8;
   localparam int B_ZERO     = 9;
   localparam int B_DEGLITCH = 10;
   localparam int B_ALWAYS   = 12;
   localparam int B_ONESHOT  = 13;
   localparam int B_CENTER   = 16;
   localparam int B_GANG     = 24;
   localparam int B_PEND     = 28;

   typedef struct packed {
      logic [NUM_CH-1:0]  gang;
      logic [NUM_CH-1:0]  center;
      logic               one_shot;
      logic               run_always;
      logic               deglitch;
      logic               zero_on_m0;
      logic               sticky;
      logic [SCALE_W-1:0] scale;
   } ctrl_t;

   function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
      ctrl_t c;
      c.scale      = w[B_SCALE_LO +: SCALE_W];
      c.sticky     = w[B_STICKY];
      c.zero_on_m0 = w[B_ZERO];
      c.deglitch   = w[B_DEGLITCH];
      c.run_always = w[B_ALWAYS];
      c.one_shot   = w[B_ONESHOT];
      c.center     = w[B_CENTER +: NUM_CH];
      c.gang       = w[B_GANG +: NUM_CH];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c,
                                                     input logic [NUM_CH-1:0] pend);
      logic [REG_W-1:0] w;
      w = '0;
      w[B_SCALE_LO +: SCALE_W] = c.scale;
      w[B_STICKY]              = c.sticky;
      w[B_ZERO]                = c.zero_on_m0;
      w[B_DEGLITCH]            = c.deglitch;
      w[B_ALWAYS]              = c.run_always;
      w[B_ONESHOT]             = c.one_shot;
      w[B_CENTER +: NUM_CH]    = c.center;
      w[B_GANG +: NUM_CH]      = c.gang;
      w[B_PEND +: NUM_CH]      = pend;
      return w;
   endfunction

endpackage

// File: rtl/pwm4_timebase.sv
module pwm4_timebase
   import pwm4_pkg::*;
#(
   parameter int CNT_W = 31,
   parameter int CMP_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_always,
   input  logic               one_shot,
   input  logic               zero_on_m0,
   input  logic               match0,
   input  logic [SCALE_W-1:0] scale,
   input  logic               load,
   input  logic [CNT_W-1:0]   load_val,
   output logic [CNT_W-1:0]   count,
   output logic [CMP_W-1:0]   scaled,
   output logic               run,
   output logic               cycle_end
);

   logic [CNT_W-1:0] shifted;
   logic             at_top;
   logic             zero_hit;

   assign shifted   = count >> scale;
   assign scaled    = shifted[CMP_W-1:0];
   assign run       = run_always | one_shot;
   assign at_top    = &count;
   assign zero_hit  = run & zero_on_m0 & match0;
   assign cycle_end = run & (zero_hit | at_top);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (run) begin
         count <= zero_hit ? '0 : count + 1'b1;
      end
   end

   // R7: running counter steps by one
   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !zero_hit && !load) |=> (count == CNT_W'($past(count) + 1'b1)));

   // R7: idle counter holds its value
   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   // R8: channel 0 match returns the counter to zero
   a_r8_zero_return: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_hit && !load) |=> (count == '0));

endmodule

// File: rtl/pwm4_compare.sv
module pwm4_compare #(
   parameter int CMP_W          = 16,
   parameter bit CENTER_SUPPORT = 1'b1
) (
   input  logic [CMP_W-1:0] scaled,
   input  logic [CMP_W-1:0] cmp_val,
   input  logic             center,
   output logic             match
);

   logic [CMP_W-1:0] cmp_in;

   generate
      if (CENTER_SUPPORT) begin : g_center
         // fold the upper half of the scaled range back down
         assign cmp_in = (center && scaled[CMP_W-1]) ? ~scaled : scaled;
      end else begin : g_edge
         logic unused_center;
         assign unused_center = center;
         assign cmp_in = scaled;
      end
   endgenerate

   assign match = (cmp_in >= cmp_val);

endmodule

// File: rtl/pwm4_outstage.sv
module pwm4_outstage (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic next_match,
   input  logic gang,
   input  logic deglitch,
   input  logic run,
   input  logic restart,
   output logic pwm
);

   logic window;
   logic held;

   assign window = match & ~(gang & next_match);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (restart) begin
         held <= 1'b0;
      end else if (window && run) begin
         held <= 1'b1;
      end
   end

   assign pwm = window | (deglitch & held);

   // R12: a deglitched output that is high while running stays high
   a_r12_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (deglitch && pwm && run && !restart) |=> (pwm || !deglitch));

endmodule

// File: rtl/pwm4_regs.sv
module pwm4_regs
   import pwm4_pkg::*;
#(
   parameter int CNT_W  = 31,
   parameter int CMP_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [REG_W-1:0]             wdata,
   output logic [REG_W-1:0]             rdata,
   input  logic                         cycle_end,
   input  logic [NUM_CH-1:0]            pend_set,
   input  logic [CNT_W-1:0]             count,
   input  logic [CMP_W-1:0]             scaled,
   output ctrl_t                        ctrl,
   output logic [NUM_CH-1:0]            pend,
   output logic [NUM_CH-1:0][CMP_W-1:0] cmp,
   output logic                         cnt_load,
   output logic [CNT_W-1:0]             cnt_load_val
);

   logic              wr_ctrl;
   logic [NUM_CH-1:0] wr_cmp;
   logic [NUM_CH-1:0] pend_sw;
   logic [NUM_CH-1:0] pend_wr;

   assign wr_ctrl      = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign cnt_load     = wr_en && (addr == ADDR_W'(OFS_COUNT));
   assign cnt_load_val = wdata[CNT_W-1:0];
   assign pend_wr      = wdata[B_PEND +: NUM_CH];

   genvar n;
   generate
      for (n = 0; n < NUM_CH; n++) begin : g_cmp_dec
         assign wr_cmp[n] = wr_en && (addr == ADDR_W'(OFS_CMP + CMP_STRIDE * n));
      end
   endgenerate

   // software view of the pending bits before the hardware set is merged
   always_comb begin
      pend_sw = pend;
      if (wr_ctrl) begin
         pend_sw = ctrl.sticky ? (pend | pend_wr) : pend_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         pend <= '0;
         cmp  <= '1;
      end else begin
         if (wr_ctrl) begin
            ctrl <= word_to_ctrl(wdata);
         end else if (cycle_end) begin
            ctrl.one_shot <= 1'b0;
         end
         pend <= pend_sw | pend_set;
         for (int i = 0; i < NUM_CH; i++) begin
            if (wr_cmp[i]) cmp[i] <= wdata[CMP_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CTRL))   rdata = ctrl_to_word(ctrl, pend);
      if (addr == ADDR_W'(OFS_COUNT))  rdata[CNT_W-1:0] = count;
      if (addr == ADDR_W'(OFS_SCALED)) rdata[CMP_W-1:0] = scaled;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(OFS_CMP + CMP_STRIDE * i)) rdata[CMP_W-1:0] = cmp[i];
      end
   end

   // R9: one-shot bit drops after the counting cycle ends
   a_r9_oneshot_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_end && ctrl.one_shot && !wr_ctrl) |=> !ctrl.one_shot);

   // R10: a hardware set is never lost, even against a software write
   a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_set) |=> ((pend & $past(pend_set)) == $past(pend_set)));

   // R11: with sticky set, no pending bit is cleared
   a_r11_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.sticky |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/pwm4_unit.sv
module pwm4_unit
   import pwm4_pkg::*;
#(
   parameter int CNT_W          = 31,
   parameter int CMP_W          = 16,
   parameter int ADDR_W         = 8,
   parameter bit CENTER_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wr_data,
   output logic [31:0]       reg_rd_data,
   output logic [3:0]        pwm_out,
   output logic [3:0]        irq
);

   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("pwm4_unit: CNT_W must fit in a register");
      end
      if (CMP_W < 2) begin : g_bad_cmp
         $error("pwm4_unit: CMP_W must be at least 2");
      end
      if (CNT_W < CMP_W + MAX_SHIFT) begin : g_bad_span
         $error("pwm4_unit: CNT_W too narrow for the largest scale");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("pwm4_unit: ADDR_W too narrow for the register map");
      end
   endgenerate

   ctrl_t                        ctrl;
   logic [NUM_CH-1:0]            pend;
   logic [NUM_CH-1:0][CMP_W-1:0] cmp;
   logic                         cnt_load;
   logic [CNT_W-1:0]             cnt_load_val;
   logic [CNT_W-1:0]             count;
   logic [CMP_W-1:0]             scaled;
   logic                         run;
   logic                         cycle_end;
   logic [NUM_CH-1:0]            match;
   logic [NUM_CH-1:0]            pend_set;
   logic                         restart;

   pwm4_regs #(.CNT_W(CNT_W), .CMP_W(CMP_W), .ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr_en),
      .addr         (reg_addr),
      .wdata        (reg_wr_data),
      .rdata        (reg_rd_data),
      .cycle_end    (cycle_end),
      .pend_set     (pend_set),
      .count        (count),
      .scaled       (scaled),
      .ctrl         (ctrl),
      .pend         (pend),
      .cmp          (cmp),
      .cnt_load     (cnt_load),
      .cnt_load_val (cnt_load_val)
   );

   pwm4_timebase #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_always (ctrl.run_always),
      .one_shot   (ctrl.one_shot),
      .zero_on_m0 (ctrl.zero_on_m0),
      .match0     (match[0]),
      .scale      (ctrl.scale),
      .load       (cnt_load),
      .load_val   (cnt_load_val),
      .count      (count),
      .scaled     (scaled),
      .run        (run),
      .cycle_end  (cycle_end)
   );

   assign restart  = cycle_end | cnt_load;
   assign pend_set = match & {NUM_CH{run}};
   assign irq      = pend;

   genvar n;
   generate
      for (n = 0; n < NUM_CH; n++) begin : g_ch
         pwm4_compare #(.CMP_W(CMP_W), .CENTER_SUPPORT(CENTER_SUPPORT)) u_cmp (
            .scaled  (scaled),
            .cmp_val (cmp[n]),
            .center  (ctrl.center[n]),
            .match   (match[n])
         );
      end
      for (n = 0; n < NUM_CH; n++) begin : g_out
         pwm4_outstage u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .match      (match[n]),
            .next_match (match[(n + 1) % NUM_CH]),
            .gang       (ctrl.gang[n]),
            .deglitch   (ctrl.deglitch),
            .run        (run),
            .restart    (restart),
            .pwm        (pwm_out[n])
         );
      end
   endgenerate

   // R10: every interrupt line mirrors the pending bit one cycle after a match
   a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (run && match[0]) |=> irq[0]);

endmodule

// File: tb/pwm4_unit_bench.sv
`timescale 1ns/100ps
module pwm4_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic [3:0]  pwm_out;
   logic [3:0]  irq;

   int  runs = 0;
   int  fails = 0;
   bit  done = 0;

   always #2.5 clk = ~clk;

   pwm4_unit u_pwm4_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_addr    (reg_addr),
      .reg_wr_data (reg_wr_data),
      .reg_rd_data (reg_rd_data),
      .pwm_out     (pwm_out),
      .irq         (irq)
   );

   localparam logic [31:0] RUN  = 32'h0000_1000;
   localparam logic [31:0] ONE  = 32'h0000_2000;
   localparam logic [31:0] ZERO = 32'h0000_0200;
   localparam logic [31:0] DEG  = 32'h0000_0400;
   localparam logic [31:0] STK  = 32'h0000_0100;

   // static compare vectors, cmp = 10, 20, 30, 40, counter stopped
   localparam int NV = 15;
   localparam logic [31:0] V_CFG [NV] = '{
      32'h0, 32'h0, 32'h0, 32'h2, 32'hF,
      32'h0001_0000, 32'h000F_0000, 32'h000F_0000,
      32'h0100_0000, 32'h0100_0000, 32'h0800_0000,
      32'h0F00_0000, 32'h0F00_0000, 32'h3, 32'h0 };
   localparam logic [31:0] V_CNT [NV] = '{
      32'd25, 32'd40, 32'd9, 32'd100, 32'h000A_0000,
      32'h0000_FFF8, 32'h0000_FFFF, 32'h0000_8000,
      32'd15, 32'd25, 32'd45,
      32'd45, 32'd35, 32'h0001_0019, 32'h0001_0005 };
   localparam logic [3:0] V_OUT [NV] = '{
      4'b0011, 4'b1111, 4'b0000, 4'b0011, 4'b0011,
      4'b1110, 4'b0000, 4'b1111,
      4'b0001, 4'b0010, 4'b0111,
      4'b0000, 4'b0100, 4'b1111, 4'b0000 };
   localparam logic [31:0] V_SCL [NV] = '{
      32'd25, 32'd40, 32'd9, 32'd25, 32'd20,
      32'hFFF8, 32'hFFFF, 32'h8000,
      32'd15, 32'd25, 32'd45,
      32'd45, 32'd35, 32'h2003, 32'd5 };
   localparam string V_REQ [NV] = '{
      "R4", "R4", "R4", "R3", "R3",
      "R5", "R5", "R5",
      "R6", "R6", "R6",
      "R6", "R6", "R3", "R3" };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      runs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr    = a;
      reg_wr_data = d;
      reg_wr_en   = 1'b1;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.1;
      d = reg_rd_data;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cmps(input logic [15:0] c0, input logic [15:0] c1,
                           input logic [15:0] c2, input logic [15:0] c3);
      wr(8'h20, {16'h0, c0});
      wr(8'h24, {16'h0, c1});
      wr(8'h28, {16'h0, c2});
      wr(8'h2C, {16'h0, c3});
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         runs++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
      rd(8'h08, d); chk("R1 count", d, 32'h0);
      rd(8'h28, d); chk("R1 cmp2", d, 32'h0000_FFFF);
      chk("R1 pwm", {28'h0, pwm_out}, 32'h0);
      chk("R1 irq", {28'h0, irq}, 32'h0);
      rd(8'h04, d); chk("R2 unmapped", d, 32'h0);

      // vector table, counter stopped
      set_cmps(16'd10, 16'd20, 16'd30, 16'd40);
      rd(8'h2C, d); chk("R2 cmp3", d, 32'd40);
      for (int i = 0; i < NV; i++) begin
         wr(8'h00, V_CFG[i]);
         wr(8'h08, V_CNT[i]);
         chk({V_REQ[i], " out"}, {28'h0, pwm_out}, {28'h0, V_OUT[i]});
         rd(8'h10, d); chk("R3 scaled", d, V_SCL[i]);
         rd(8'h00, d); chk("R2 ctrl", d, V_CFG[i]);
      end

      // R7 R8 continuous with zero-on-match, period 5
      wr(8'h00, 32'h0);
      wr(8'h08, 32'h0);
      set_cmps(16'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      wr(8'h00, RUN | ZERO);
      tick(7);
      rd(8'h08, d); chk("R8 count", d, 32'd2);
      chk("R10 irq", {28'h0, irq}, 32'h1);

      // R11 sticky
      wr(8'h00, RUN | ZERO | STK | 32'h1000_0000);
      wr(8'h00, STK);
      chk("R11 sticky keep", {28'h0, irq}, 32'h1);
      wr(8'h00, 32'h0);
      chk("R11 sticky last", {28'h0, irq}, 32'h1);
      wr(8'h00, 32'h0);
      chk("R11 clear", {28'h0, irq}, 32'h0);

      // R10 hardware set against software clear in the same cycle
      wr(8'h08, 32'h0);
      wr(8'h20, 32'h0);
      wr(8'h00, RUN);
      tick(2);
      wr(8'h00, RUN);
      chk("R10 collision", {28'h0, irq}, 32'h1);
      wr(8'h00, 32'h0);
      wr(8'h00, 32'h0);
      chk("R10 sw clear", {28'h0, irq}, 32'h0);

      // R9 R7 one-shot ended by wrap
      wr(8'h20, 32'hFFFF);
      wr(8'h08, 32'h7FFF_FFFD);
      wr(8'h00, ONE);
      tick(2);
      rd(8'h08, d); chk("R7 near top", d, 32'h7FFF_FFFF);
      tick(1);
      rd(8'h08, d); chk("R7 wrap", d, 32'h0);
      rd(8'h00, d); chk("R9 wrap clear", d, 32'hF000_0000);
      tick(5);
      rd(8'h08, d); chk("R7 stopped", d, 32'h0);
      wr(8'h00, 32'h0);

      // R9 one-shot ended by zero-on-match
      wr(8'h08, 32'h0);
      wr(8'h20, 32'd3);
      wr(8'h00, ONE | ZERO);
      tick(3);
      rd(8'h08, d); chk("R8 pre", d, 32'd3);
      rd(8'h00, d); chk("R9 still set", d & ONE, ONE);
      tick(1);
      rd(8'h00, d); chk("R9 zero clear", d & ONE, 32'h0);
      tick(4);
      rd(8'h08, d); chk("R9 halted", d, 32'h0);
      wr(8'h00, 32'h0);

      // R12 deglitch, channel 1 ganged to channel 2, period 9
      set_cmps(16'd8, 16'd3, 16'd5, 16'hFFFF);
      wr(8'h08, 32'h0);
      wr(8'h00, RUN | ZERO | 32'h0200_0000);
      tick(6);
      chk("R6 gang window", {28'h0, pwm_out}, 32'b0100);
      wr(8'h00, 32'h0);
      wr(8'h08, 32'h0);
      wr(8'h00, RUN | ZERO | DEG | 32'h0200_0000);
      tick(6);
      rd(8'h08, d); chk("R12 count", d, 32'd6);
      chk("R12 held", {28'h0, pwm_out}, 32'b0110);
      tick(3);
      rd(8'h08, d); chk("R8 period", d, 32'd0);
      chk("R12 released", {28'h0, pwm_out}, 32'b0000);
      wr(8'h00, 32'h0);

      done = 1;
      summary();
      $finish;
   end

endmodule